// File: doc/BRIEF.md
# Dual Countdown Timer

The block contains two independent decrementing counters, each reached through one single-cycle register port. Software writes a start value. It then picks a counter width of 16 or 32 bits, a tick divider of 1, 16 or 256, and one of three end-of-count behaviours: stop, reload, or wrap to all ones. When a counter moves from 1 to 0 it raises a raw interrupt flag. The flag, gated by a per-timer enable, drives that timer's interrupt pin.

A second "background" write path changes only the reload value. A running periodic count therefore keeps its current value and takes up the new period at its next wrap.

Each timer is driven by a state machine with three states. `ST_IDLE` means the counter is switched off and holds. `ST_COUNT` means the divider runs and the counter steps. `ST_DONE` means a one-shot count has reached zero and is parked. The transitions are named as follows. *start* (IDLE→COUNT) happens when the enable bit is seen set. *halt* (COUNT→IDLE or DONE→IDLE) happens when the enable bit is seen clear. *expire* (COUNT→DONE) happens on a step at a count of 1 or 0 in one-shot mode. *rearm* (DONE→COUNT) happens on a start-value write, or when one-shot mode is switched off.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, each timer reads control = 0x20, current value = 0x0000FFFF, reload = 0, raw and masked status = 0, and both interrupt pins are low.
- R2: Address bits [5:2] of the byte address select the register. Bit 5 picks timer 0 or 1. Bits [4:2] pick the register: 0 start/reload value (rw), 1 current value (ro), 2 control (rw), 3 flag clear (wo, reads 0), 4 raw status (ro, bit 0), 5 masked status (ro, bit 0), 6 background reload (rw, reads the reload value), 7 reads 0.
- R3: A write to register 0 sets both the counter and the reload value on that edge, and restarts the tick divider.
- R4: A write to register 6 changes only the reload value. The current count is not disturbed.
- R5: The counter changes only while control bit 7 (enable) is set, apart from writes to register 0. Each divider step lowers it by one.
- R6: Control bits [3:2] set the divider: 00 steps on every clock, 01 on every 16th, 10 and 11 on every 256th. The divider starts counting on the first enabled cycle.
- R7: A step taken at a count of 1 puts the counter at 0 and sets the raw flag.
- R8: With control bit 6 set (periodic), a step taken at count 0 loads the reload value.
- R9: With control bit 6 clear (free-running), a step taken at count 0 loads all ones of the selected width.
- R10: With control bit 0 set (one-shot), the counter stops at 0 and does not reload. A write to register 0, or clearing bit 0, resumes counting.
- R11: Control bit 1 clear selects 16 bits. The value reads back only bits 15:0, with the upper bits zero, and counting uses only bits 15:0 of a loaded value. Bit 1 set selects 32 bits.
- R12: Any write to register 3 clears the raw flag. If the same edge also sets the flag, the flag stays set.
- R13: Masked status and the interrupt pin equal raw flag AND control bit 5.
- R14: A write to register 0 on the edge where a 1-to-0 step would occur takes priority. The new value is loaded and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the count tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address bits [5:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 2 | Per-timer interrupt, bit i for timer i |

## Verification
Two actions on one timer can fall on the same clock edge. One is a software write: a flag-clear write or a start-value write. The other is the counter stepping from 1 to 0. The bench loads a small count with the divider at 1 and counts the idle cycles. This lines the clear write up exactly with the terminal step, and in a second case lines up a fresh start-value write with it. The raw flag and the counter value are then read through the bus, and a reference model running beside the design is compared against them and against both interrupt pins on every clock. The flag must survive the clear in the first case. In the second case the new value must be loaded and no flag raised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } tmr_state_e;

    localparam logic [2:0] REG_START = 3'd0;
    localparam logic [2:0] REG_VALUE = 3'd1;
    localparam logic [2:0] REG_CTRL  = 3'd2;
    localparam logic [2:0] REG_CLEAR = 3'd3;
    localparam logic [2:0] REG_RAW   = 3'd4;
    localparam logic [2:0] REG_MASKD = 3'd5;
    localparam logic [2:0] REG_BGREL = 3'd6;

    localparam int CB_ONESHOT = 0;
    localparam int CB_WIDE    = 1;
    localparam int CB_DIV_LO  = 2;
    localparam int CB_IE      = 5;
    localparam int CB_PERIOD  = 6;
    localparam int CB_EN      = 7;

    localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] div,
    output logic       step
);
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << (PRE_W / 2)) - 1);
    localparam logic [PRE_W-1:0] LIM_TOP = '1;

    logic [PRE_W-1:0] pc_q;
    logic             at_lim;

    always_comb begin
        unique case (div)
            2'b00:   at_lim = 1'b1;
            2'b01:   at_lim = (pc_q == LIM_MID);
            default: at_lim = (pc_q == LIM_TOP);
        endcase
    end

    assign step = run && !clr && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pc_q <= '0;
        else if (!run || clr || step) pc_q <= '0;
        else                         pc_q <= pc_q + 1'b1;
    end

    AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (step && div != 2'b00) |=> (!step || div == 2'b00)); // R6
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_wr,
    input  logic             bg_wr,
    input  logic             ctrl_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [7:0]       ctrl_o,
    output logic             ris_o,
    output logic             mis_o
);
    localparam logic [CNT_W-1:0] MASK_NARROW = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, mask, cur;
    logic [7:0]       ctrl_q;
    logic             ris_q, step, hit_one;
    logic             en, oneshot, periodic, wide, ie;

    assign en       = ctrl_q[CB_EN];
    assign oneshot  = ctrl_q[CB_ONESHOT];
    assign periodic = ctrl_q[CB_PERIOD];
    assign wide     = ctrl_q[CB_WIDE];
    assign ie       = ctrl_q[CB_IE];
    assign mask     = wide ? '1 : MASK_NARROW;
    assign cur      = cnt_q & mask;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == ST_COUNT),
        .clr   (ld_wr),
        .div   (ctrl_q[CB_DIV_LO+1:CB_DIV_LO]),
        .step  (step)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: start, halt, expire, rearm
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (en) st_d = ST_COUNT;
            ST_COUNT: begin
                if (!en)                                   st_d = ST_IDLE;
                else if (oneshot && step && cur <= ONE)    st_d = ST_DONE;
            end
            ST_DONE: begin
                if (!en)                      st_d = ST_IDLE;
                else if (ld_wr || !oneshot)   st_d = ST_COUNT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // next count
    always_comb begin
        cnt_d   = cnt_q;
        hit_one = 1'b0;
        if (ld_wr) begin
            cnt_d = wdata;
        end else if (step) begin
            if (cur == ONE) begin
                cnt_d   = '0;
                hit_one = 1'b1;
            end else if (cur == '0) begin
                if (!oneshot) cnt_d = periodic ? (rel_q & mask) : mask;
            end else begin
                cnt_d = cur - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            rel_q  <= '0;
            ctrl_q <= CTRL_RESET;
            ris_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (ld_wr || bg_wr) rel_q  <= wdata;
            if (ctrl_wr)        ctrl_q <= wdata[7:0];
            if (hit_one)        ris_q  <= 1'b1;
            else if (clr_wr)    ris_q  <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        value_o  = cnt_q & mask;
        reload_o = rel_q;
        ctrl_o   = ctrl_q;
        ris_o    = ris_q;
        mis_o    = ris_q & ie;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> (cnt_q == $past(wdata))); // R3
    AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_wr && !ld_wr && !step) |=> $stable(cnt_q)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !ld_wr) |=> $stable(cnt_q)); // R5
    AST_FLAG_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur == ONE) |=> ris_q); // R7
    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !ld_wr) |=> $stable(cnt_q)); // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(step && cur == ONE)) |=> !ris_q); // R12
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import tmr_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int CNT_W  = 32,
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_TMR-1:0]  irq
);
    localparam int IDX_W = ADDR_W - 5;

    logic [IDX_W-1:0]            idx;
    logic [2:0]                  off;
    logic [N_TMR-1:0][CNT_W-1:0] rd_w;
    logic [N_TMR-1:0]            hit;

    assign idx = bus_addr[ADDR_W-1:5];
    assign off = bus_addr[4:2];

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic [CNT_W-1:0] value, reload;
        logic [7:0]       ctrl;
        logic             ris, mis, wr_here;

        assign hit[i]   = bus_sel && (idx == IDX_W'(i));
        assign wr_here  = hit[i] && bus_wr;

        tmr_channel #(.CNT_W(CNT_W), .HALF_W(HALF_W), .PRE_W(PRE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_wr    (wr_here && off == REG_START),
            .bg_wr    (wr_here && off == REG_BGREL),
            .ctrl_wr  (wr_here && off == REG_CTRL),
            .clr_wr   (wr_here && off == REG_CLEAR),
            .wdata    (bus_wdata),
            .value_o  (value),
            .reload_o (reload),
            .ctrl_o   (ctrl),
            .ris_o    (ris),
            .mis_o    (mis)
        );

        assign irq[i] = mis;

        always_comb begin
            unique case (off)
                REG_START, REG_BGREL: rd_w[i] = reload;
                REG_VALUE:            rd_w[i] = value;
                REG_CTRL:             rd_w[i] = CNT_W'(ctrl);
                REG_RAW:              rd_w[i] = CNT_W'(ris);
                REG_MASKD:            rd_w[i] = CNT_W'(mis);
                default:              rd_w[i] = '0;
            endcase
        end

        AST_PIN_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            !ris |-> !irq[i]); // R13
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++)
            if (hit[i]) bus_rdata = rd_w[i];
    end
endmodule

// File: tb/tb_dual_countdown_timer.sv
`timescale 1ns/1ps
module tb_dual_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int vectors = 0, misses = 0, cycles = 0;

    always #4 clk = ~clk;

    dual_countdown_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference
    logic [31:0] m_cnt[2], m_rel[2];
    logic [7:0]  m_ctrl[2];
    bit          m_ris[2];
    int          m_pc[2], m_st[2];
    logic [31:0] t_mask, t_ce, t_cnt;
    int          t_lim, t_st;
    bit          t_hit, t_ld, t_bg, t_cw, t_cl, t_step, t_set, t_ris;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 32'hFFFF_FFFF; m_rel[i] = 0; m_ctrl[i] = 8'h20;
                m_ris[i] = 0; m_pc[i] = 0; m_st[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                t_hit  = bus_sel && bus_wr && (bus_addr[5] == i[0]);
                t_ld   = t_hit && bus_addr[4:2] == 3'd0;
                t_bg   = t_hit && bus_addr[4:2] == 3'd6;
                t_cw   = t_hit && bus_addr[4:2] == 3'd2;
                t_cl   = t_hit && bus_addr[4:2] == 3'd3;
                t_mask = m_ctrl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                t_ce   = m_cnt[i] & t_mask;
                case (m_ctrl[i][3:2])
                    2'b00: t_lim = 0;
                    2'b01: t_lim = 15;
                    default: t_lim = 255;
                endcase
                t_step = (m_st[i] == 1) && !t_ld && (m_pc[i] == t_lim);
                t_set = 0; t_cnt = m_cnt[i];
                if (t_ld) t_cnt = bus_wdata;
                else if (t_step) begin
                    if (t_ce == 1) begin t_cnt = 0; t_set = 1; end
                    else if (t_ce == 0) begin
                        if (!m_ctrl[i][0]) t_cnt = m_ctrl[i][6] ? (m_rel[i] & t_mask) : t_mask;
                    end else t_cnt = t_ce - 1;
                end
                t_ris = m_ris[i];
                if (t_cl) t_ris = 0;
                if (t_set) t_ris = 1;
                t_st = m_st[i];
                case (m_st[i])
                    0: if (m_ctrl[i][7]) t_st = 1;
                    1: if (!m_ctrl[i][7]) t_st = 0;
                       else if (m_ctrl[i][0] && t_step && t_ce <= 1) t_st = 2;
                    default: if (!m_ctrl[i][7]) t_st = 0;
                       else if (t_ld || !m_ctrl[i][0]) t_st = 1;
                endcase
                m_pc[i] = (m_st[i] != 1 || t_ld || t_step) ? 0 : m_pc[i] + 1;
                m_cnt[i] = t_cnt;
                m_ris[i] = t_ris;
                m_st[i] = t_st;
                if (t_ld || t_bg) m_rel[i] = bus_wdata;
                if (t_cw) m_ctrl[i] = bus_wdata[7:0];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int i = a[5];
        logic [31:0] mk = m_ctrl[i][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        case (a[4:2])
            3'd0, 3'd6: return m_rel[i];
            3'd1: return m_cnt[i] & mk;
            3'd2: return {24'd0, m_ctrl[i]};
            3'd4: return {31'd0, m_ris[i]};
            3'd5: return {31'd0, m_ris[i] & m_ctrl[i][5]};
            default: return 0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // interrupt pins against the model on every clock (R13)
    always @(negedge clk) begin
        if (rst_n) check({30'd0, irq}, {30'd0, m_ris[1] & m_ctrl[1][5], m_ris[0] & m_ctrl[0][5]}, "R13 irq pins");
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            misses++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a[5:2]; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_sel = 0; bus_wr = 0;
        end
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a[5:2];
        #1 check(bus_rdata, m_read(a), tag);
    endtask

    task automatic rd_lit(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a[5:2];
        #1 check(bus_rdata, exp, tag);
        check(bus_rdata, m_read(a), tag);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state, R2 map of both timers
        rd_lit(6'h08, 32'h20, "R1 ctrl reset");
        rd_lit(6'h04, 32'h0000_FFFF, "R1 R11 value reset");
        rd_lit(6'h00, 32'h0, "R1 reload reset");
        rd_lit(6'h10, 32'h0, "R1 raw reset");
        rd_lit(6'h28, 32'h20, "R1 R2 timer1 ctrl");
        rd_lit(6'h34, 32'h0, "R1 R2 timer1 masked");
        rd_lit(6'h1C, 32'h0, "R2 unused slot");

        // idle counter holds (R5)
        idle(5);
        rd_lit(6'h04, 32'h0000_FFFF, "R5 disabled holds");

        // timer 1 periodic in the background (R2)
        wr(6'h20, 32'h30);
        wr(6'h28, 32'hE2);

        // periodic, divider 1, BG reload (R3 R4 R7 R8)
        wr(6'h08, 32'hE2);
        wr(6'h00, 32'd4);
        wr(6'h18, 32'd9);
        rd_lit(6'h04, 32'd3, "R4 count undisturbed");
        idle(2);
        rd_lit(6'h04, 32'd0, "R7 reached zero");
        rd_lit(6'h04, 32'd9, "R8 R4 reload at wrap");
        rd_lit(6'h10, 32'd1, "R7 raw set");
        rd_lit(6'h00, 32'd9, "R4 reload readback");
        for (int k = 0; k < 30; k++) rd(6'h04, "R8 periodic run");

        // flag clear (R12)
        wr(6'h0C, 32'hDEAD);
        rd(6'h10, "R12 clear");
        wr(6'h2C, 32'h0);

        // clear meets terminal step: set wins (R12)
        wr(6'h00, 32'd3);
        idle(2);
        wr(6'h0C, 32'h1);
        rd_lit(6'h10, 32'd1, "R12 set beats clear");
        wr(6'h0C, 32'h1);
        // start write meets terminal step (R14)
        wr(6'h00, 32'd2);
        idle(1);
        wr(6'h00, 32'd7);
        rd_lit(6'h04, 32'd7, "R14 load wins value");
        rd_lit(6'h10, 32'd0, "R14 no flag");

        // masked status with enable off (R13)
        idle(8);
        wr(6'h08, 32'hC2);
        rd(6'h14, "R13 masked off");
        rd(6'h10, "R13 raw still");
        wr(6'h0C, 32'h0);

        // divider 16, 256, and code 11 (R6)
        wr(6'h08, 32'hE6);
        wr(6'h00, 32'd2);
        for (int k = 0; k < 60; k++) rd(6'h04, "R6 div16");
        wr(6'h08, 32'hEA);
        wr(6'h00, 32'd2);
        for (int k = 0; k < 40; k++) begin idle(20); rd(6'h04, "R6 div256"); end
        wr(6'h08, 32'hEE);
        wr(6'h00, 32'd1);
        for (int k = 0; k < 15; k++) begin idle(20); rd(6'h10, "R6 div code 11"); end

        // 16-bit free-running (R9 R11)
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'hA0);
        wr(6'h00, 32'h0001_2345);
        rd_lit(6'h04, 32'h2345, "R11 narrow load");
        wr(6'h00, 32'h0001_0002);
        idle(3);
        rd_lit(6'h04, 32'h0000_FFFF, "R9 R11 free wrap");
        wr(6'h08, 32'h82);
        rd(6'h04, "R11 wide view");

        // one-shot (R10)
        wr(6'h08, 32'hE3);
        wr(6'h00, 32'd3);
        idle(10);
        rd_lit(6'h04, 32'd0, "R10 parked at zero");
        rd_lit(6'h10, 32'd1, "R10 flag");
        wr(6'h00, 32'd2);
        rd_lit(6'h04, 32'd2, "R10 rearm by load");
        idle(6);
        rd_lit(6'h04, 32'd0, "R10 parked again");
        wr(6'h08, 32'hE2);
        idle(3);
        rd(6'h04, "R10 rearm by mode");
        for (int k = 0; k < 20; k++) rd(6'h24, "R2 timer1 value");

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule